// File: doc/BRIEF.md
# Serial DAC Input Register with Power-Down Control

This block is the digital front end of a 16-bit serial digital-to-analog converter. A host writes 24-bit frames over a three-wire serial link: a serial clock, a data line and an active-low frame select. The block brings the three wires into the system clock domain and shifts in data on each detected falling edge of the serial clock. When the 24th bit arrives it loads a 16-bit conversion code and a 2-bit power-down selector, and both take effect in the same cycle.

The outputs drive the analog section. They are the code bus, an amplifier enable, and three mutually exclusive termination selects: a 1k pull-down, a 100k pull-down and a high-impedance output. Power-down never clears the stored code. When the output stage returns to normal operation, a wake-up counter keeps the amplifier disabled for a set number of system clock cycles while the analog circuitry settles.

Top module: `sdac_frontend`

## Requirements
- R1: After reset the code output is zero, no termination select is asserted and the amplifier enable is high.
- R2: A frame is 24 bits sent most significant bit first, one bit taken on each falling serial-clock edge while the frame select is low. Frame bits 15..0 become the code output.
- R3: Frame bits 17..16 select the output mode: 00 normal (no select asserted), 01 asserts the 1k select, 10 asserts the 100k select, 11 asserts the high-impedance select. At no time is more than one select asserted.
- R4: A power-down mode deasserts the amplifier enable and does not clear the code register: the code output holds the code field of the frame that requested power-down.
- R5: A frame that returns the mode to normal from any power-down mode clears all selects at once. The amplifier enable then stays low for WAKE_CYC system clock cycles before it rises.
- R6: If the frame select rises before 24 bits have been received, the partial frame is discarded and neither code nor mode changes. The next complete frame is received normally.
- R7: Frame bits 23..18 have no effect on any output.
- R8: The frame select may stay low across pauses of any length between serial clock bursts, for example three 8-bit bursts. The resulting frame is identical to one sent without pauses.
- R9: The update takes place on the 24th bit without waiting for the frame select to rise. Further serial clock edges in the same frame are ignored.
- R10: Code and mode outputs change only in the cycle after a complete frame is accepted, and always together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host, asynchronous, idles high |
| sync_n | input | 1 | Active-low frame select from host, asynchronous |
| din | input | 1 | Serial data from host, asynchronous |
| dac_code | output | 16 | Conversion code to the analog core |
| amp_en | output | 1 | Output amplifier enable |
| sel_1k | output | 1 | Connect output to ground through 1k |
| sel_100k | output | 1 | Connect output to ground through 100k |
| sel_hiz | output | 1 | Leave output open-circuit |

## Verification
The bench targets the following corner cases:
- A frame cut short by the frame select. A design that commits on the select's rising edge, or fails to clear its bit counter, would then load a corrupted code.
- Frames broken into bytes with long idle gaps. A receiver that times out or resets its count between bursts would lose bits.
- A return from power-down, checked both inside and after the wake window. A design that reloads no counter, or clears it too early, would raise the amplifier enable immediately.
- Frames whose ignored top bits are set or whose code field is unchanged across a mode change, and extra clock edges after the 24th bit. These expose a decoder that reads the wrong bit positions, clears the code on power-down, or keeps shifting past the frame end.

// File: rtl/sdac_pkg.sv
// Shared types for the serial DAC front end.
// Assumes the 2-bit mode field encoding defined by the frame format.
package sdac_pkg;
    typedef enum logic [1:0] {
        PD_NONE = 2'b00,
        PD_1K   = 2'b01,
        PD_100K = 2'b10,
        PD_HIZ  = 2'b11
    } pd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
// Multi-bit synchronizer: each asynchronous input passes through its own
// chain of STAGES flops. Assumes the inputs are slow compared with clk,
// so per-bit skew of one cycle is harmless. STAGES must be at least 2.
module sdac_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d_async[g]};
        end

        assign d_sync[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/sdac_shift.sv
// Frame receiver: detects falling serial-clock edges in the clk domain and
// shifts the data bit in while the frame select is low. Only the low
// PAYLOAD_W bits are kept, so the upper frame bits fall off the register.
// It emits a one-cycle commit pulse with the payload on the final bit.
// Edges beyond FRAME_BITS are ignored. A high frame select clears the count.
module sdac_shift #(
    parameter int FRAME_BITS = 24,
    parameter int PAYLOAD_W  = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 sync_n_s,
    input  logic                 din_s,
    output logic                 commit,
    output logic [PAYLOAD_W-1:0] word
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic                 sclk_d;
    logic                 sclk_fall;
    logic [CNT_W-1:0]     bit_cnt;
    logic [PAYLOAD_W-1:0] sreg;

    assign sclk_fall = sclk_d & ~sclk_s;

    // Track the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    // Count and shift bits, and commit the payload on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sreg    <= '0;
            commit  <= 1'b0;
            word    <= '0;
        end else begin
            commit <= 1'b0;
            if (sync_n_s) begin
                bit_cnt <= '0;
            end else if (sclk_fall && bit_cnt < CNT_W'(FRAME_BITS)) begin
                sreg    <= {sreg[PAYLOAD_W-2:0], din_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                    commit <= 1'b1;
                    word   <= {sreg[PAYLOAD_W-2:0], din_s};
                end
            end
        end
    end
endmodule

// File: rtl/sdac_outctl.sv
// Output control: holds the code and mode registers, decodes the mode into
// termination selects and runs the wake-up counter on a return to normal.
// Assumes commit is a single-cycle pulse with word valid in that cycle.
module sdac_outctl
    import sdac_pkg::*;
#(
    parameter int CODE_W   = 16,
    parameter int WAKE_CYC = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [CODE_W+1:0] word,
    output logic [CODE_W-1:0] dac_code,
    output logic              amp_en,
    output logic              sel_1k,
    output logic              sel_100k,
    output logic              sel_hiz
);
    localparam int TMR_W = (WAKE_CYC < 1) ? 1 : $clog2(WAKE_CYC + 1);

    pd_mode_e   mode_q;
    pd_mode_e   next_mode;
    logic [TMR_W-1:0] wake_tmr;

    assign next_mode = pd_mode_e'(word[CODE_W+1:CODE_W]);

    // Load code and mode together, and reload the wake timer on a return to normal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
            mode_q   <= PD_NONE;
            wake_tmr <= '0;
        end else if (commit) begin
            dac_code <= word[CODE_W-1:0];
            mode_q   <= next_mode;
            if (next_mode == PD_NONE && mode_q != PD_NONE)
                wake_tmr <= TMR_W'(WAKE_CYC);
            else if (next_mode != PD_NONE)
                wake_tmr <= '0;
            else if (wake_tmr != '0)
                wake_tmr <= wake_tmr - 1'b1;
        end else if (wake_tmr != '0) begin
            wake_tmr <= wake_tmr - 1'b1;
        end
    end

    // Decode the mode into the amplifier enable and one-hot selects.
    always_comb begin
        amp_en   = 1'b0;
        sel_1k   = 1'b0;
        sel_100k = 1'b0;
        sel_hiz  = 1'b0;
        unique case (mode_q)
            PD_NONE: amp_en   = (wake_tmr == '0);
            PD_1K:   sel_1k   = 1'b1;
            PD_100K: sel_100k = 1'b1;
            PD_HIZ:  sel_hiz  = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdac_frontend.sv
// Top level of the serial DAC front end: synchronizes the three serial
// wires, receives 24-bit frames and drives the code and output-stage
// controls. Assumes the serial clock runs well below clk/4.
module sdac_frontend #(
    parameter int CODE_W      = 16,
    parameter int FRAME_BITS  = 24,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYC    = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              din,
    output logic [CODE_W-1:0] dac_code,
    output logic              amp_en,
    output logic              sel_1k,
    output logic              sel_100k,
    output logic              sel_hiz
);
    localparam int PAYLOAD_W = CODE_W + 2;

    logic [2:0]           wires_s;
    logic                 frame_commit;
    logic [PAYLOAD_W-1:0] frame_word;

    sdac_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sclk, sync_n, din}),
        .d_sync  (wires_s)
    );

    sdac_shift #(
        .FRAME_BITS (FRAME_BITS),
        .PAYLOAD_W  (PAYLOAD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (wires_s[2]),
        .sync_n_s (wires_s[1]),
        .din_s    (wires_s[0]),
        .commit   (frame_commit),
        .word     (frame_word)
    );

    sdac_outctl #(
        .CODE_W   (CODE_W),
        .WAKE_CYC (WAKE_CYC)
    ) u_outctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (frame_commit),
        .word     (frame_word),
        .dac_code (dac_code),
        .amp_en   (amp_en),
        .sel_1k   (sel_1k),
        .sel_100k (sel_100k),
        .sel_hiz  (sel_hiz)
    );
endmodule

// File: rtl/sdac_frontend_chk.sv
// Checker for the serial DAC front end, bound to the top module.
// Relates the receiver's commit pulse to the output registers and checks
// the output-stage control rules.
module sdac_frontend_chk #(
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic [CODE_W-1:0] dac_code,
    input logic              amp_en,
    input logic              sel_1k,
    input logic              sel_100k,
    input logic              sel_hiz
);
    logic [2:0] sels;
    assign sels = {sel_1k, sel_100k, sel_hiz};

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sels));

    assert_amp_off_in_pd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|sels) |-> !amp_en);

    assert_code_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(commit));

    assert_mode_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sels) |-> $past(commit));

    assert_wake_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|sels) |-> !amp_en);

    assert_amp_rise_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_en) |-> $stable(sels));
endmodule

bind sdac_frontend sdac_frontend_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (frame_commit),
    .dac_code (dac_code),
    .amp_en   (amp_en),
    .sel_1k   (sel_1k),
    .sel_100k (sel_100k),
    .sel_hiz  (sel_hiz)
);

// File: tb/sdac_frontend_tb.sv
`timescale 1ns/1ps
module sdac_frontend_tb;
    localparam int WAKE = 625;
    localparam int HP   = 4;

    typedef struct packed {
        logic [23:0] frame;
        logic [15:0] code;
        logic [1:0]  mode;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{24'h001234, 16'h1234, 2'd0},
        '{24'hFCABCD, 16'hABCD, 2'd0},
        '{24'h01FFFF, 16'hFFFF, 2'd1},
        '{24'h020001, 16'h0001, 2'd2},
        '{24'h038000, 16'h8000, 2'd3},
        '{24'h005A5A, 16'h5A5A, 2'd0},
        '{24'hA9C3C3, 16'hC3C3, 2'd1},
        '{24'h000000, 16'h0000, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sync_n = 1'b1;
    logic din = 1'b0;
    logic [15:0] dac_code;
    logic amp_en, sel_1k, sel_100k, sel_hiz;

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sdac_frontend #(.WAKE_CYC(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
        .dac_code(dac_code), .amp_en(amp_en), .sel_1k(sel_1k),
        .sel_100k(sel_100k), .sel_hiz(sel_hiz)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: act=running exp=finished");
            report();
            $finish;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] stage_exp(input logic [1:0] m);
        case (m)
            2'd0:    return 4'b1000;
            2'd1:    return 4'b0100;
            2'd2:    return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic check_all(input string req, input logic [15:0] code, input logic [1:0] m);
        check(req, {16'h0, dac_code}, {16'h0, code});
        check(req, {28'h0, amp_en, sel_1k, sel_100k, sel_hiz}, {28'h0, stage_exp(m)});
    endtask

    // Send the first nbits of f, MSB first, pausing gap cycles between bytes.
    task automatic send_bits(input logic [23:0] f, input int nbits, input int gap);
        sync_n = 1'b0;
        waitc(HP);
        for (int i = 0; i < nbits; i++) begin
            if (gap > 0 && i > 0 && (i % 8) == 0) waitc(gap);
            sclk = 1'b1;
            din  = f[23-i];
            waitc(HP);
            sclk = 1'b0;
            waitc(HP);
        end
        sclk = 1'b1;
        waitc(HP);
    endtask

    task automatic end_frame();
        sync_n = 1'b1;
        waitc(HP);
    endtask

    task automatic send_frame(input logic [23:0] f, input int gap);
        send_bits(f, 24, gap);
        end_frame();
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        // R1: reset state
        check_all("R1 reset", 16'h0000, 2'd0);

        // Table walk: R2 R3 R7
        for (int v = 0; v < NV; v++) begin
            send_frame(VECS[v].frame, 0);
            waitc(WAKE + 40);
            check_all("R2/R3/R7 vector", VECS[v].code, VECS[v].mode);
        end

        // R4: entering power-down keeps the code, amplifier off
        send_frame(24'h007777, 0);
        waitc(WAKE + 40);
        send_frame(24'h017777, 0);
        waitc(20);
        check_all("R4 enter pd", 16'h7777, 2'd1);

        // R5: leaving power-down, wake window
        send_frame(24'h002222, 0);
        waitc(16);
        check("R5 selects cleared", {29'h0, sel_1k, sel_100k, sel_hiz}, 32'h0);
        check("R5 amp low early", {31'h0, amp_en}, 32'h0);
        check("R5 code", {16'h0, dac_code}, 32'h2222);
        waitc(WAKE - 60);
        check("R5 amp low late", {31'h0, amp_en}, 32'h0);
        waitc(80);
        check("R5 amp high after wake", {31'h0, amp_en}, 32'h1);

        // R6: aborted frame leaves everything unchanged
        send_bits(24'h039999, 20, 0);
        end_frame();
        waitc(40);
        check_all("R6 abort", 16'h2222, 2'd0);
        send_frame(24'h003333, 0);
        waitc(40);
        check_all("R6 after abort", 16'h3333, 2'd0);

        // R8: three bursts with long pauses
        send_frame(24'h024444, 50);
        waitc(40);
        check_all("R8 bursts", 16'h4444, 2'd2);

        // R9: update on 24th bit with select still low; extra edges ignored
        send_bits(24'h005555, 24, 0);
        waitc(20);
        check("R9 update before select rises", {16'h0, dac_code}, 32'h5555);
        send_bits(24'hC00000, 2, 0);
        waitc(20);
        check("R9 extra edges ignored", {16'h0, dac_code}, 32'h5555);
        end_frame();
        waitc(WAKE + 40);
        check_all("R9 final", 16'h5555, 2'd0);

        // R10: code and mode move together
        send_frame(24'h03AAAA, 0);
        waitc(30);
        check_all("R10 joint update", 16'hAAAA, 2'd3);

        // R1: reset again from a power-down state
        rst_n = 1'b0;
        waitc(3);
        rst_n = 1'b1;
        waitc(3);
        check_all("R1 re-reset", 16'h0000, 2'd0);

        report();
        $finish;
    end
endmodule